// File: doc/BRIEF.md
# Single-wire bus slave slot engine

This block sits behind the pin of an open-drain single-wire bus and turns the line's low pulses into events for the logic above it. It oversamples the line with the system clock, measures each low period with one cycle counter and classifies it. A short or medium low is a data slot. A low at least as long as the reset minimum is a bus reset, and the block answers it with a presence pulse. The block never drives the line high. It only raises an active-high pull-low enable, and the pad or board resolves the line as a wired-AND.

In a write slot the master decides the bit by how long it holds the line low, and the block strobes the sampled bit out. Before a read slot the upper layer offers one bit with a valid/ready pair. When the master opens the slot, the block consumes that bit and holds the line low for a fixed time if the bit is 0. A speed input selects one of two timing sets, standard or overdrive. Every threshold is given in nanoseconds and converted to clock cycles from the clock-rate parameter. Byte assembly (least significant bit first on the wire) and command decoding belong to the layer above.

Top module: `owire_slot_slave`

## Requirements
- R1: While rst_ni is low and after it rises with the line idle high, pull_o, rx_valid_o, reset_o and tx_ready_o are all 0.
- R2: With tx_valid_i low at the falling edge of a slot, the block samples the line once, at the sample time after that edge (30 us standard, 3.5 us overdrive). It then gives exactly one single-cycle rx_valid_o pulse with rx_bit_o = 1 if the line was high and 0 if it was low.
- R3: With tx_valid_i high at the falling edge of a slot, the block raises tx_ready_o for one cycle, gives no rx_valid_o pulse and captures tx_bit_i. For a captured 0 it asserts pull_o from the slot start until the hold time (30 us standard, 3 us overdrive) and then releases it. For a captured 1 it never asserts pull_o.
- R4: A low lasting at least the reset minimum (480 us standard, 48 us overdrive) produces a single-cycle reset_o pulse when the line returns high. Like every long low it first yields the 0 bit of R2.
- R5: After reset_o the block leaves the line free for the presence delay (20 us standard, 3 us overdrive). It then asserts pull_o for the presence width (120 us standard, 12 us overdrive).
- R6: A low longer than a slot but shorter than the reset minimum gives only the 0 bit. It gives no reset_o and no presence pulse.
- R7: od_i = 1 selects the overdrive set and od_i = 0 the standard set for every threshold. od_i is held stable within a slot.
- R8: pull_o is never high for more than the standard presence width plus one cycle.
- R9: rx_valid_o and reset_o are never high together, and neither stays high for two consecutive cycles.
- R10: The line passes through a two-flop synchroniser, so a strobed rx_bit_o equals dq_i as sampled three clock edges before the strobe is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dq_i | input | 1 | Resolved bus line level (asynchronous) |
| od_i | input | 1 | Speed select: 1 overdrive, 0 standard |
| tx_valid_i | input | 1 | A bit is offered for the next read slot |
| tx_bit_i | input | 1 | Bit value to return in the read slot |
| tx_ready_o | output | 1 | One-cycle pulse: offered bit consumed |
| rx_valid_o | output | 1 | One-cycle strobe of a received bit |
| rx_bit_o | output | 1 | Received bit value, valid with rx_valid_o |
| reset_o | output | 1 | One-cycle pulse: bus reset detected |
| pull_o | output | 1 | Pull-low enable for the open-drain driver |

## Verification
The assertions check the following on every cycle: the single-cycle shape and mutual exclusion of the bit and reset strobes, the one-cycle consume pulse, the bound on how long the line can be held low, and the three-edge latency from pin to sampled bit. Other behaviour only shows in the bench's scenarios, because it depends on what the master does over whole slots. This covers which bit value comes out of a write slot, whether a read slot returns the offered bit at the master's sampling instant and releases in time, when the presence pulse starts and how long it lasts, and that a medium-length low causes no reset. The bench runs each of these at both speeds.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_PD_WAIT,
    ST_PD_DRIVE,
    ST_PD_REL
  } owire_st_e;

  localparam int unsigned SPD_STD = 0;
  localparam int unsigned SPD_OD  = 1;
  localparam int unsigned N_SPD   = 2;

  // nanoseconds to clock cycles, rounded up
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int unsigned maxu(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owire_sync.sv
module owire_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/owire_thresh.sv
module owire_thresh
  import owire_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned CW          = 16,
  parameter int unsigned SAMP_STD_NS = 30000,
  parameter int unsigned SAMP_OD_NS  = 3500,
  parameter int unsigned HOLD_STD_NS = 30000,
  parameter int unsigned HOLD_OD_NS  = 3000,
  parameter int unsigned RST_STD_NS  = 480000,
  parameter int unsigned RST_OD_NS   = 48000,
  parameter int unsigned PDH_STD_NS  = 20000,
  parameter int unsigned PDH_OD_NS   = 3000,
  parameter int unsigned PDL_STD_NS  = 120000,
  parameter int unsigned PDL_OD_NS   = 12000
) (
  input  logic          od_i,
  output logic [CW-1:0] samp_o,
  output logic [CW-1:0] hold_o,
  output logic [CW-1:0] rst_o,
  output logic [CW-1:0] pdh_o,
  output logic [CW-1:0] pdl_o
);
  logic [CW-1:0] samp_tab [N_SPD];
  logic [CW-1:0] hold_tab [N_SPD];
  logic [CW-1:0] rst_tab  [N_SPD];
  logic [CW-1:0] pdh_tab  [N_SPD];
  logic [CW-1:0] pdl_tab  [N_SPD];

  for (genvar g = 0; g < N_SPD; g++) begin : g_spd
    localparam int unsigned SAMP_NS = (g == SPD_OD) ? SAMP_OD_NS : SAMP_STD_NS;
    localparam int unsigned HOLD_NS = (g == SPD_OD) ? HOLD_OD_NS : HOLD_STD_NS;
    localparam int unsigned RST_NS  = (g == SPD_OD) ? RST_OD_NS  : RST_STD_NS;
    localparam int unsigned PDH_NS  = (g == SPD_OD) ? PDH_OD_NS  : PDH_STD_NS;
    localparam int unsigned PDL_NS  = (g == SPD_OD) ? PDL_OD_NS  : PDL_STD_NS;
    assign samp_tab[g] = CW'(ns2cyc(SAMP_NS, CLK_MHZ));
    assign hold_tab[g] = CW'(ns2cyc(HOLD_NS, CLK_MHZ));
    assign rst_tab[g]  = CW'(ns2cyc(RST_NS,  CLK_MHZ));
    assign pdh_tab[g]  = CW'(ns2cyc(PDH_NS,  CLK_MHZ));
    assign pdl_tab[g]  = CW'(ns2cyc(PDL_NS,  CLK_MHZ));
  end

  assign samp_o = samp_tab[od_i];
  assign hold_o = hold_tab[od_i];
  assign rst_o  = rst_tab[od_i];
  assign pdh_o  = pdh_tab[od_i];
  assign pdl_o  = pdl_tab[od_i];
endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
  import owire_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dq_s_i,
  input  logic [CW-1:0] samp_i,
  input  logic [CW-1:0] hold_i,
  input  logic [CW-1:0] rst_i,
  input  logic [CW-1:0] pdh_i,
  input  logic [CW-1:0] pdl_i,
  input  logic          tx_valid_i,
  input  logic          tx_bit_i,
  output logic          tx_ready_o,
  output logic          rx_valid_o,
  output logic          rx_bit_o,
  output logic          reset_o,
  output logic          pull_o
);
  owire_st_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      rd_q       <= 1'b0;
      pull_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_bit_o   <= 1'b0;
      reset_o    <= 1'b0;
      tx_ready_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      reset_o    <= 1'b0;
      tx_ready_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (!dq_s_i) begin
            st_q       <= ST_SLOT;
            cnt_q      <= CW'(1);
            rd_q       <= tx_valid_i;
            tx_ready_o <= tx_valid_i;
            pull_o     <= tx_valid_i & ~tx_bit_i;
          end
        end
        ST_SLOT: begin
          if (cnt_q < rst_i) cnt_q <= cnt_q + 1'b1;
          if (rd_q && cnt_q == hold_i) pull_o <= 1'b0;
          if (!rd_q && cnt_q == samp_i) begin
            rx_valid_o <= 1'b1;
            rx_bit_o   <= dq_s_i;
          end
          // slot ends on the line high once the sample point is past
          if (dq_s_i && cnt_q > samp_i) begin
            pull_o <= 1'b0;
            if (cnt_q >= rst_i) begin
              reset_o <= 1'b1;
              cnt_q   <= '0;
              st_q    <= ST_PD_WAIT;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_PD_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= pdh_i) begin
            pull_o <= 1'b1;
            cnt_q  <= '0;
            st_q   <= ST_PD_DRIVE;
          end
        end
        ST_PD_DRIVE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q >= pdl_i) begin
            pull_o <= 1'b0;
            st_q   <= ST_PD_REL;
          end
        end
        ST_PD_REL: begin
          if (dq_s_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owire_slot_slave.sv
module owire_slot_slave
  import owire_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SAMP_STD_NS = 30000,
  parameter int unsigned SAMP_OD_NS  = 3500,
  parameter int unsigned HOLD_STD_NS = 30000,
  parameter int unsigned HOLD_OD_NS  = 3000,
  parameter int unsigned RST_STD_NS  = 480000,
  parameter int unsigned RST_OD_NS   = 48000,
  parameter int unsigned PDH_STD_NS  = 20000,
  parameter int unsigned PDH_OD_NS   = 3000,
  parameter int unsigned PDL_STD_NS  = 120000,
  parameter int unsigned PDL_OD_NS   = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dq_i,
  input  logic od_i,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  output logic tx_ready_o,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic reset_o,
  output logic pull_o
);
  localparam int unsigned MAX_NS  = maxu(maxu(RST_STD_NS, PDL_STD_NS),
                                         maxu(RST_OD_NS, PDL_OD_NS));
  localparam int unsigned MAX_CYC = ns2cyc(MAX_NS, CLK_MHZ) + 2;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          dq_s;
  logic [CW-1:0] samp_c, hold_c, rst_c, pdh_c, pdl_c;

  owire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dq_i),
    .q_o   (dq_s)
  );

  owire_thresh #(
    .CLK_MHZ    (CLK_MHZ),
    .CW         (CW),
    .SAMP_STD_NS(SAMP_STD_NS), .SAMP_OD_NS(SAMP_OD_NS),
    .HOLD_STD_NS(HOLD_STD_NS), .HOLD_OD_NS(HOLD_OD_NS),
    .RST_STD_NS (RST_STD_NS),  .RST_OD_NS (RST_OD_NS),
    .PDH_STD_NS (PDH_STD_NS),  .PDH_OD_NS (PDH_OD_NS),
    .PDL_STD_NS (PDL_STD_NS),  .PDL_OD_NS (PDL_OD_NS)
  ) u_thresh (
    .od_i  (od_i),
    .samp_o(samp_c),
    .hold_o(hold_c),
    .rst_o (rst_c),
    .pdh_o (pdh_c),
    .pdl_o (pdl_c)
  );

  owire_slot_fsm #(.CW(CW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dq_s_i    (dq_s),
    .samp_i    (samp_c),
    .hold_i    (hold_c),
    .rst_i     (rst_c),
    .pdh_i     (pdh_c),
    .pdl_i     (pdl_c),
    .tx_valid_i(tx_valid_i),
    .tx_bit_i  (tx_bit_i),
    .tx_ready_o(tx_ready_o),
    .rx_valid_o(rx_valid_o),
    .rx_bit_o  (rx_bit_o),
    .reset_o   (reset_o),
    .pull_o    (pull_o)
  );
endmodule

// File: rtl/owire_slot_chk.sv
module owire_slot_chk
  import owire_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PDL_STD_NS  = 120000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic dq_i,
  input logic pull_o,
  input logic rx_valid_o,
  input logic rx_bit_o,
  input logic reset_o,
  input logic tx_ready_o
);
  localparam int unsigned PULL_MAX = ns2cyc(PDL_STD_NS, CLK_MHZ) + 1;

  logic [31:0] pull_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pull_run_q <= '0;
    else if (pull_o) pull_run_q <= pull_run_q + 1;
    else             pull_run_q <= '0;
  end

  p_pull_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_run_q <= PULL_MAX);

  p_rx_rst_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && reset_o));

  p_rx_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_rst_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |=> !reset_o);

  p_ack_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |=> !tx_ready_o);

  p_rx_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_bit_o == $past(dq_i, SYNC_STAGES + 1)));
endmodule

bind owire_slot_slave owire_slot_chk #(
  .CLK_MHZ    (CLK_MHZ),
  .SYNC_STAGES(SYNC_STAGES),
  .PDL_STD_NS (PDL_STD_NS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dq_i      (dq_i),
  .pull_o    (pull_o),
  .rx_valid_o(rx_valid_o),
  .rx_bit_o  (rx_bit_o),
  .reset_o   (reset_o),
  .tx_ready_o(tx_ready_o)
);

// File: tb/owire_slot_slave_test.sv
`timescale 1ns/1ps
module owire_slot_slave_test;
  // thresholds computed for 10 cycles per microsecond
  localparam int US = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_pull = 1'b0;
  logic od = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic tx_ready, rx_valid, rx_bit, rst_ev, pull;
  wire  line = ~(m_pull | pull);

  always #2 clk = ~clk;

  owire_slot_slave #(.CLK_MHZ(US)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dq_i      (line),
    .od_i      (od),
    .tx_valid_i(tx_valid),
    .tx_bit_i  (tx_bit),
    .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid),
    .rx_bit_o  (rx_bit),
    .reset_o   (rst_ev),
    .pull_o    (pull)
  );

  typedef struct {
    bit    is_rst;
    bit    b;
    string req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   n_vec = 0;
  int   n_bad = 0;
  int   n_ack = 0;

  task automatic chk(string req, int act, int exp, string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi, string what);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic push(bit is_rst, bit b, string req);
    exp_t x;
    x.is_rst = is_rst;
    x.b      = b;
    x.req    = req;
    q.push_back(x);
  endtask

  // monitor: compare design events against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && tx_ready) n_ack++;
    if (rst_n && (rx_valid || rst_ev)) begin
      n_vec++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected event: act rx=%0b rst=%0b exp none", rx_valid, rst_ev);
      end else begin
        e = q.pop_front();
        if (e.is_rst != rst_ev || (!e.is_rst && rx_bit != e.b)) begin
          n_bad++;
          $display("FAIL %s event: act rst=%0b bit=%0b exp rst=%0b bit=%0b",
                   e.req, rst_ev, rx_bit, e.is_rst, e.b);
        end
      end
    end
  end

  task automatic hold_low(int n);
    @(posedge clk) m_pull <= 1'b1;
    repeat (n) @(posedge clk);
    m_pull <= 1'b0;
  endtask

  // R2: write slot
  task automatic slot_write(bit b);
    int low  = b ? (od ? 1*US : 5*US) : (od ? 7*US : 70*US);
    int slot = od ? 10*US : 80*US;
    push(1'b0, b, "R2");
    hold_low(low);
    repeat (slot - low) @(posedge clk);
  endtask

  // R3: read slot
  task automatic slot_read(bit b);
    int acks = n_ack;
    int samp = od ? 15 : 12*US;
    int late = od ? 5*US : 45*US;
    int slot = od ? 10*US : 80*US;
    @(posedge clk);
    tx_valid <= 1'b1;
    tx_bit   <= b;
    hold_low(US);
    tx_valid <= 1'b0;
    repeat (samp - US - 1) @(posedge clk);
    @(negedge clk);
    chk("R3", line, b, "line at master sample");
    repeat (late - samp) @(posedge clk);
    @(negedge clk);
    chk("R3", line, 1, "line released after hold");
    chk("R3", n_ack - acks, 1, "consume pulses");
    repeat (slot - late) @(posedge clk);
  endtask

  // R4/R5: reset and presence
  task automatic do_reset();
    int c1 = 0;
    int c2 = 0;
    int low  = od ? 50*US : 500*US;
    push(1'b0, 1'b0, "R4");
    push(1'b1, 1'b0, "R4");
    hold_low(low);
    @(negedge clk);
    while (line !== 1'b0 && c1 < 1000*US) begin
      @(negedge clk);
      c1++;
    end
    while (line === 1'b0 && c2 < 1000*US) begin
      @(negedge clk);
      c2++;
    end
    chk_rng("R5", c1, od ? 2*US : 15*US, od ? 6*US : 60*US, "presence delay cycles");
    chk_rng("R5", c2, od ? 8*US : 60*US, od ? 24*US : 240*US, "presence low cycles");
    repeat (od ? 10*US : 100*US) @(posedge clk);
  endtask

  // R6: medium low, neither slot nor reset
  task automatic mid_low();
    int lows = 0;
    push(1'b0, 1'b0, "R6");
    hold_low(od ? 30*US : 200*US);
    repeat (od ? 60*US : 600*US) begin
      @(negedge clk);
      if (line === 1'b0) lows++;
    end
    chk("R6", lows, 0, "line low cycles after medium low");
  endtask

  initial begin : main
    repeat (5) @(negedge clk);
    chk("R1", pull, 0, "pull in reset");
    chk("R1", rx_valid | rst_ev | tx_ready, 0, "strobes in reset");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", pull, 0, "pull after reset");
    chk("R1", rx_valid | rst_ev | tx_ready, 0, "strobes after reset");

    od = 1'b0;
    do_reset();
    slot_write(1'b1);
    slot_write(1'b0);
    slot_write(1'b1);
    slot_write(1'b1);
    slot_write(1'b0);
    slot_read(1'b0);
    slot_read(1'b1);
    mid_low();

    // R7: overdrive set
    od = 1'b1;
    do_reset();
    slot_write(1'b0);
    slot_write(1'b1);
    slot_write(1'b0);
    slot_read(1'b1);
    slot_read(1'b0);
    mid_low();
    od = 1'b0;
    slot_write(1'b0);
    slot_write(1'b1);

    repeat (20) @(posedge clk);
    chk("R9", q.size(), 0, "scoreboard items left");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: act running exp done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule